// File: doc/BRIEF.md
# External Bus Cycle Termination Controller

This block ends each cycle that the chip masters on its external bus. A cycle opens with a one-clock start strobe. A chip-select hit flag, a wait-state count and a self-acknowledge mode bit, all sampled with that strobe, decide who ends the cycle. The block can end it by driving the acknowledge line itself after the wait states. Otherwise an external device ends it by pulling the acknowledge line. A bus watchdog, or an error raised by an external device, can end the cycle with an error instead.

The acknowledge and error lines are read through a one-clock registered copy, which eases timing at high clock rates. The block drives its tri-state acknowledge and error pins only in the clocks where the contention rules allow it. For the address and control drivers it gives a hold signal, and for the read-data register it gives a capture strobe. The internal requester receives a one-clock done pulse or a one-clock error pulse, never both.

Top module: `bus_term_ctl`

## Requirements
- R1: In a cycle started with the chip-select flag low, ack_oe stays 0 for every clock of the cycle. The cycle ends on the registered copy of ack_in: if ack_in is high at the clock edge that ends busy clock j, the registered copy is high in busy clock j+1, and done pulses in the clock after that.
- R2: In every busy clock of a cycle the acknowledge pin does not drive (no chip-select, or chip-select with external-acknowledge mode), data_cap is 1.
- R3: In a cycle with chip-select high and ext_ack_mode low, ack_oe is 1 in every busy clock. If the cycle ends normally, ack_out is 1 only in busy clock N, where N is cs_wait sampled at the start and busy clocks are counted from 0. done pulses in the following clock.
- R4: In a cycle with chip-select high and ext_ack_mode high, ack_oe stays 0 and cs_wait has no effect. The cycle ends on the registered ack_in, with the timing of R1.
- R5: When no cycle is active and bus_grant is 1, ack_oe is 1 and ack_out is 0. When no cycle is active and bus_grant is 0, ack_oe is 0.
- R6: With mon_en set and mon_limit = L (not 0), if nothing ends the cycle earlier, err_out is 1 in busy clock L and fail pulses in the next clock. When the watchdog and the self-acknowledge fall in the same busy clock, the error wins and ack_out stays 0.
- R7: err_oe is 1 only in a clock where err_out is 1 and in the single clock after it, when err_out is 0.
- R8: err_in is acted on through a one-clock registered copy, with the same timing as ack_in in R1. If the registered error arrives in the same busy clock as the registered acknowledge, or earlier, the cycle ends with fail and not with done.
- R9: If err_in is still high at the edge that starts a new cycle, the registered copy ends that new cycle with fail in its first busy clock. fail is visible one clock later.
- R10: With mon_en at 0, or with mon_limit at 0, no watchdog error is produced, however long the cycle lasts.
- R11: done and fail are one-clock pulses, never high together, and addr_hold is 0 while either is high. A cyc_start that arrives while a cycle is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Starts a cycle when the controller is idle |
| cs_hit | input | 1 | Cycle targets a chip-select region |
| cs_wait | input | WS_W | Wait states before self-acknowledge |
| ext_ack_mode | input | 1 | 1: an external device acknowledges even on chip-select hits |
| bus_grant | input | 1 | External bus is granted to this block |
| mon_en | input | 1 | Bus watchdog enable |
| mon_limit | input | TO_W | Watchdog timeout in busy clocks; 0 disables it |
| ack_in | input | 1 | Acknowledge line as seen at the pin, 1 = asserted |
| err_in | input | 1 | Error line as seen at the pin, 1 = asserted |
| ack_out | output | 1 | Acknowledge drive value, 1 = asserted |
| ack_oe | output | 1 | Acknowledge output enable |
| err_out | output | 1 | Error drive value, 1 = asserted |
| err_oe | output | 1 | Error output enable |
| addr_hold | output | 1 | Keep address and control driven |
| data_cap | output | 1 | Capture read data this clock |
| done | output | 1 | One-clock pulse: cycle ended normally |
| fail | output | 1 | One-clock pulse: cycle ended with an error |

## Verification
The watchdog and the acknowledge can both end a cycle in the same busy clock. This happens when the self-acknowledge wait count equals the watchdog limit, and when a registered external error meets a registered external acknowledge. The bench sweeps the wait count against the limit, and the error clock against the acknowledge clock, over a small grid. From each pair it works out the first clock in which the cycle can end, and it expects fail whenever the error clock comes at or before the acknowledge clock. In the self-acknowledge case it also checks that ack_out stays low in the clock where the error wins.

// File: rtl/bterm_pkg.sv
package bterm_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} bterm_st_e;
   localparam int unsigned LINE_ACK = 0;
   localparam int unsigned LINE_ERR = 1;
   localparam int unsigned N_LINES  = 2;
endpackage

// File: rtl/bterm_sample.sv
// Registered copies of the externally driven termination lines.
module bterm_sample #(
   parameter int unsigned N      = 2,
   parameter int unsigned STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad_n
      $error("bterm_sample: N must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("bterm_sample: STAGES must be at least 1");
   end

   logic [N-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/bterm_wait.sv
// Down-counter for the self-acknowledge wait states.
module bterm_wait #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         run,
   input  logic [W-1:0] init,
   output logic         expired
);
   if (W < 1) begin : g_bad_w
      $error("bterm_wait: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= init;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/bterm_mon.sv
// Bus watchdog: counts busy clocks since the cycle start and flags the limit.
module bterm_mon #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         run,
   input  logic         enable,
   input  logic [W-1:0] limit,
   output logic         fire
);
   localparam logic [W-1:0] CNT_MAX = '1;

   if (W < 2) begin : g_bad_w
      $error("bterm_mon: W must be at least 2");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clear)                 cnt <= '0;
      else if (run && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   assign fire = run && enable && (limit != '0) && (cnt == limit);
endmodule

// File: rtl/bus_term_ctl.sv
module bus_term_ctl
   import bterm_pkg::*;
#(
   parameter int unsigned WS_W = 4,
   parameter int unsigned TO_W = 6,
   parameter int unsigned LAT  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cyc_start,
   input  logic            cs_hit,
   input  logic [WS_W-1:0] cs_wait,
   input  logic            ext_ack_mode,
   input  logic            bus_grant,
   input  logic            mon_en,
   input  logic [TO_W-1:0] mon_limit,
   input  logic            ack_in,
   input  logic            err_in,
   output logic            ack_out,
   output logic            ack_oe,
   output logic            err_out,
   output logic            err_oe,
   output logic            addr_hold,
   output logic            data_cap,
   output logic            done,
   output logic            fail
);
   if (LAT != 1) begin : g_bad_lat
      $error("bus_term_ctl: termination timing assumes LAT == 1");
   end

   bterm_st_e           st;
   logic                cyc_cs, cyc_ext;
   logic [N_LINES-1:0]  line_d, line_q;
   logic                ack_q, err_q;
   logic                busy, start_ok, int_mode;
   logic                wexp, tmo, err_now, ok_now;
   logic                done_q, fail_q, rel_q;

   assign busy     = (st == ST_BUSY);
   assign start_ok = (st == ST_IDLE) && cyc_start;
   assign int_mode = cyc_cs && !cyc_ext;

   assign line_d[LINE_ACK] = ack_in;
   assign line_d[LINE_ERR] = err_in;

   bterm_sample #(.N(N_LINES), .STAGES(LAT)) u_samp (
      .clk(clk), .rst_n(rst_n), .d(line_d), .q(line_q));

   assign ack_q = line_q[LINE_ACK];
   assign err_q = line_q[LINE_ERR];

   bterm_wait #(.W(WS_W)) u_wait (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .run(busy),
      .init(cs_wait), .expired(wexp));

   bterm_mon #(.W(TO_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .clear(start_ok), .run(busy),
      .enable(mon_en), .limit(mon_limit), .fire(tmo));

   // Error has priority over a same-clock acknowledge.
   assign err_now = busy && (err_q || tmo);
   assign ok_now  = busy && (int_mode ? wexp : ack_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cyc_cs  <= 1'b0;
         cyc_ext <= 1'b0;
      end else if (start_ok) begin
         st      <= ST_BUSY;
         cyc_cs  <= cs_hit;
         cyc_ext <= ext_ack_mode;
      end else if (err_now || ok_now) begin
         st      <= ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         rel_q  <= 1'b0;
      end else begin
         done_q <= ok_now && !err_now;
         fail_q <= err_now;
         rel_q  <= tmo;
      end
   end

   assign ack_oe    = busy ? int_mode : bus_grant;
   assign ack_out   = busy && int_mode && wexp && !err_now;
   assign err_out   = tmo;
   assign err_oe    = tmo || rel_q;
   assign addr_hold = busy;
   assign data_cap  = busy && (!int_mode || ack_out);
   assign done      = done_q;
   assign fail      = fail_q;
endmodule

// File: rtl/bus_term_chk.sv
module bus_term_chk (
   input logic clk,
   input logic rst_n,
   input logic cyc_cs,
   input logic cyc_ext,
   input logic bus_grant,
   input logic ack_out,
   input logic ack_oe,
   input logic err_out,
   input logic err_oe,
   input logic addr_hold,
   input logic data_cap,
   input logic done,
   input logic fail
);
   assert_no_ack_drive_noncs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hold && !cyc_cs |-> !ack_oe);

   assert_capture_every_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hold && !(cyc_cs && !cyc_ext) |-> data_cap);

   assert_self_ack_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hold && cyc_cs && !cyc_ext |-> ack_oe);

   assert_ext_mode_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hold && cyc_ext |-> !ack_oe);

   assert_idle_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_hold && bus_grant |-> ack_oe && !ack_out);

   assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_hold && !bus_grant |-> !ack_oe);

   assert_timeout_ends_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_out |=> fail && !addr_hold);

   assert_err_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_out |=> err_oe && !err_out);

   assert_err_oe_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_oe && !err_out |-> $past(err_out));

   assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |=> !(done || fail));

   assert_idle_on_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> !addr_hold && $past(addr_hold));
endmodule

bind bus_term_ctl bus_term_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cyc_cs(cyc_cs), .cyc_ext(cyc_ext),
   .bus_grant(bus_grant), .ack_out(ack_out), .ack_oe(ack_oe),
   .err_out(err_out), .err_oe(err_oe), .addr_hold(addr_hold),
   .data_cap(data_cap), .done(done), .fail(fail));

// File: tb/sim_bus_term_ctl.sv
`timescale 1ns/1ps
module sim_bus_term_ctl;
   localparam int unsigned WS_W = 4;
   localparam int unsigned TO_W = 6;
   localparam int NONE = 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 0, cs_hit = 0, ext_ack_mode = 0, bus_grant = 1, mon_en = 0;
   logic [WS_W-1:0] cs_wait = '0;
   logic [TO_W-1:0] mon_limit = '0;
   logic ack_in = 0, err_in = 0;
   logic ack_out, ack_oe, err_out, err_oe, addr_hold, data_cap, done, fail;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   bus_term_ctl #(.WS_W(WS_W), .TO_W(TO_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cs_hit(cs_hit),
      .cs_wait(cs_wait), .ext_ack_mode(ext_ack_mode), .bus_grant(bus_grant),
      .mon_en(mon_en), .mon_limit(mon_limit), .ack_in(ack_in), .err_in(err_in),
      .ack_out(ack_out), .ack_oe(ack_oe), .err_out(err_out), .err_oe(err_oe),
      .addr_hold(addr_hold), .data_cap(data_cap), .done(done), .fail(fail));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One full cycle. Busy clocks are counted from 0; inputs change and outputs
   // are observed at the falling edge inside each clock.
   task automatic run(input bit cs, input bit ext, input int n, input bit men,
                      input int lim, input int ack_at, input int err_at,
                      input bit pre_err, input bit stray, input bit grant);
      bit self_ack = cs && !ext;
      int a  = self_ack ? n : ((ack_at >= 0) ? ack_at + 1 : NONE);
      int ee = pre_err ? 0 : ((err_at >= 0) ? err_at + 1 : NONE);
      int lt = (men && lim != 0) ? lim : NONE;
      int e  = (ee < lt) ? ee : lt;
      bit exp_fail = (e <= a);
      int t  = (exp_fail ? e : a) + 1;
      @(negedge clk);
      bus_grant = grant;
      @(negedge clk);
      chk("R5 idle ack_oe", int'(ack_oe), int'(grant));
      chk("R5 idle ack_out", int'(ack_out), 0);
      cs_hit = cs; ext_ack_mode = ext; cs_wait = WS_W'(n);
      mon_en = men; mon_limit = TO_W'(lim);
      cyc_start = 1; err_in = pre_err; ack_in = 0;
      for (int k = 0; k <= t + 1; k++) begin
         @(negedge clk);
         cyc_start = (stray && k == 1) ? 1'b1 : 1'b0;
         ack_in = (k == ack_at);
         err_in = (k == err_at);
         if (k < t) begin
            chk("R11 busy hold", int'(addr_hold), 1);
            chk("R11 no early pulse", int'(done || fail), 0);
            if (!cs) chk("R1 no ack drive", int'(ack_oe), 0);
            if (cs && ext) chk("R4 no ack drive", int'(ack_oe), 0);
            if (!self_ack) chk("R2 capture", int'(data_cap), 1);
            if (self_ack) begin
               chk("R3 ack_oe", int'(ack_oe), 1);
               chk("R3 ack_out", int'(ack_out), int'(k == n && e != n));
            end
            chk("R6 err_out", int'(err_out), int'(k == lt));
            chk("R7 err_oe", int'(err_oe), int'(k == lt));
         end else if (k == t) begin
            chk(exp_fail ? "R8 fail end" : "R1 done end", int'(fail), int'(exp_fail));
            chk("R11 done", int'(done), int'(!exp_fail));
            chk("R11 idle at end", int'(addr_hold), 0);
            chk("R7 release", int'(err_oe), int'(lt == t - 1));
            chk("R7 err_out low", int'(err_out), 0);
            chk("R5 grant after", int'(ack_oe), int'(grant));
         end else begin
            chk("R11 one pulse", int'(done || fail), 0);
            chk("R11 stays idle", int'(addr_hold), 0);
         end
      end
      @(negedge clk);
      ack_in = 0; err_in = 0; cyc_start = 0; bus_grant = 1;
   endtask

   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset hold", int'(addr_hold), 0);
      chk("R11 reset pulses", int'(done || fail), 0);
      chk("R7 reset err_oe", int'(err_oe), 0);
      chk("R5 reset ack_oe", int'(ack_oe), 1);
      rst_n = 1;
      // R3: self-acknowledge over every wait count
      for (int n = 0; n < 16; n++) run(1, 0, n, 0, 0, -1, -1, 0, 0, 1);
      // R1, R2: no chip-select, external acknowledge at several clocks
      for (int j = 0; j < 8; j++) run(0, 0, 3, 0, 0, j, -1, 0, 0, 1);
      // R4: chip-select with external acknowledge; wait count 0 must not end it
      for (int j = 0; j < 8; j++) run(1, 1, 0, 0, 0, j, -1, 0, 0, 1);
      // R6, R7: watchdog sweep with no acknowledge
      for (int l = 1; l < 13; l++) run(0, 0, 0, 1, l, -1, -1, 0, 0, 1);
      // R6: wait count against watchdog limit, same-clock collisions included
      for (int n = 1; n < 7; n++)
         for (int l = 1; l < 7; l++) run(1, 0, n, 1, l, -1, -1, 0, 0, 1);
      // R8: external error against external acknowledge
      for (int j = 0; j < 5; j++)
         for (int r = 0; r < 5; r++) run(0, 0, 0, 0, 0, j, r, 0, 0, 1);
      run(1, 0, 6, 0, 0, -1, 2, 0, 0, 1);   // R8 error before self-acknowledge
      // R9: error line still high when the next cycle starts
      run(0, 0, 0, 0, 0, 4, -1, 1, 0, 1);
      run(1, 0, 5, 0, 0, -1, -1, 1, 0, 1);
      // R10: watchdog disabled or limit zero
      run(0, 0, 0, 0, 5, 20, -1, 0, 0, 1);
      run(0, 0, 0, 1, 0, 40, -1, 0, 0, 1);
      // R11: start strobe during an active cycle is ignored
      run(0, 0, 0, 0, 0, 5, -1, 0, 1, 1);
      run(1, 0, 7, 0, 0, -1, -1, 0, 1, 1);
      // R5: bus not granted
      run(0, 0, 0, 0, 0, 2, -1, 0, 0, 0);
      run(1, 0, 3, 0, 0, -1, -1, 0, 0, 0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule